// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is a bus slave on an APB-style interface. It holds the control registers for up to four general-purpose I/O ports. Each port has an output-value register, a direction register and a read-only register that shows the state of the external pins. The output-value and direction registers drive the pin outputs and the per-pin output enables. The pin inputs pass through a two-stage synchroniser before software can read them. Port count and port width are parameters, and the port width can be at most 32.

The address map is fixed, and software depends on it. Each port's output-value and direction registers sit as a pair, and successive pairs are 0x0C apart. The pin-state registers are grouped together, starting at 0x50 with 4-byte spacing. The window from 0x30 to 0x4C belongs to a separate interrupt and debounce block and is not decoded here. Every transfer completes in its first access phase, with no wait states.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every output-value and direction register is zero, so `pinOut` and `pinOe` are all zero and every pin is an input.
- R2: A write access to offset 0x0C*p (port p, p < NUM_PORTS) loads bits [PORT_W-1:0] of `pwdata` into that port's output-value register. The register drives `pinOut[p*PORT_W +: PORT_W]` from the clock edge that ends the access, and it reads back at the same offset.
- R3: A write access to offset 0x0C*p + 0x04 loads that port's direction register, which drives `pinOe` for that port and reads back at the same offset. A direction bit of 1 makes the pin an output.
- R4: A read at offset 0x50 + 4*p returns port p's pin inputs after two clock stages. A change on `pinIn` shows up only after two rising edges.
- R5: A read of any offset that maps to no register returns zero. This covers misaligned offsets, the 0x30 to 0x4C window and the registers of ports at or above NUM_PORTS.
- R6: A write to a pin-state register or to an unmapped offset changes no register, no `pinOut` bit and no `pinOe` bit.
- R7: `pready` is always high, so each transfer completes in its first access phase.
- R8: A register changes only in an access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone, or `penable` without `psel`, changes nothing.
- R9: Register bits at and above PORT_W read as zero, and writes to them are dropped.
- R10: `prdata` is zero whenever no read access phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in a read access phase |
| pready | output | 1 | Transfer complete, tied high |
| pinIn | input | NUM_PORTS*PORT_W | External pin levels, port p in slice p |
| pinOut | output | NUM_PORTS*PORT_W | Pin output values |
| pinOe | output | NUM_PORTS*PORT_W | Pin output enables, 1 = drive |

## Verification
Read data is combinational from the registers, so the bench samples `prdata` 1 ns after the falling edge that raises `penable`, before the edge that ends the transfer. A write takes effect on the rising edge that ends its access phase, so `pinOut` and `pinOe` are compared at the next falling edge. A pin change is due only after two rising edges. The bench changes `pinIn` on the falling edge where a read's setup phase starts, expects the old value in that read's access phase and the new value in the next read. Random transfers to mapped, reserved, misaligned and absent-port offsets are compared against a register model kept in the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int MAX_PORTS   = 4;
  localparam int DATA_W      = 32;
  localparam int PORT_STRIDE = 'h0C;
  localparam int DIR_OFS     = 'h04;
  localparam int PIN_BASE    = 'h50;
  localparam int PIN_STRIDE  = 'h04;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2,
    RD_PIN  = 2'd3
  } rdKindE;

  typedef struct packed {
    logic [MAX_PORTS-1:0] wrDataStb;
    logic [MAX_PORTS-1:0] wrDirStb;
    rdKindE               rdKind;
    logic [1:0]           rdPort;
  } bankCtlT;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstn,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;

  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn)                 warmCnt <= 2'd0;
    else if (warmCnt != 2'd2)  warmCnt <= warmCnt + 2'd1;
  end

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstn)
    (warmCnt == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output bankCtlT           ctl
);
  logic accessWr;
  logic accessRd;
  logic [MAX_PORTS-1:0] hitData;
  logic [MAX_PORTS-1:0] hitDir;
  logic [MAX_PORTS-1:0] hitPin;

  assign accessWr = psel & penable & pwrite;
  assign accessRd = psel & penable & ~pwrite;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_hit
    if (p < NUM_PORTS) begin : g_live
      assign hitData[p] = (paddr == ADDR_W'(p * PORT_STRIDE));
      assign hitDir[p]  = (paddr == ADDR_W'(p * PORT_STRIDE + DIR_OFS));
      assign hitPin[p]  = (paddr == ADDR_W'(PIN_BASE + p * PIN_STRIDE));
    end else begin : g_absent
      assign hitData[p] = 1'b0;
      assign hitDir[p]  = 1'b0;
      assign hitPin[p]  = 1'b0;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.wrDataStb = hitData & {MAX_PORTS{accessWr}};
    ctl.wrDirStb  = hitDir  & {MAX_PORTS{accessWr}};
    ctl.rdKind    = RD_NONE;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (accessRd && hitData[p]) begin
        ctl.rdKind = RD_DATA;
        ctl.rdPort = 2'(p);
      end else if (accessRd && hitDir[p]) begin
        ctl.rdKind = RD_DIR;
        ctl.rdPort = 2'(p);
      end else if (accessRd && hitPin[p]) begin
        ctl.rdKind = RD_PIN;
        ctl.rdPort = 2'(p);
      end
    end
  end

  // R8
  strobe_access_chk: assert property (@(posedge clk) disable iff (!rstn)
    (|{ctl.wrDataStb, ctl.wrDirStb}) |-> (psel && penable && pwrite));

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstn)
    $onehot0({ctl.wrDataStb, ctl.wrDirStb}));

  // R10
  rd_only_access_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctl.rdKind != RD_NONE) |-> (psel && penable && !pwrite));
endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstn,
  input  bankCtlT                     ctl,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinOe
);
  localparam int BUS_W = NUM_PORTS * PORT_W;

  logic [NUM_PORTS-1:0][PORT_W-1:0] dataReg;
  logic [NUM_PORTS-1:0][PORT_W-1:0] dirReg;
  logic [NUM_PORTS-1:0][PORT_W-1:0] pinSync;
  logic [PORT_W-1:0]                rdSel;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (ctl.wrDataStb[p]) dataReg[p] <= wdata[PORT_W-1:0];
        if (ctl.wrDirStb[p])  dirReg[p]  <= wdata[PORT_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_bank_sync #(.W(PORT_W)) u_sync (
      .clk  (clk),
      .rstn (rstn),
      .din  (pinIn[p*PORT_W +: PORT_W]),
      .dout (pinSync[p])
    );
    assign pinOut[p*PORT_W +: PORT_W] = dataReg[p];
    assign pinOe[p*PORT_W +: PORT_W]  = dirReg[p];
  end

  always_comb begin
    rdSel = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (ctl.rdPort == 2'(p)) begin
        case (ctl.rdKind)
          RD_DATA: rdSel = dataReg[p];
          RD_DIR:  rdSel = dirReg[p];
          RD_PIN:  rdSel = pinSync[p];
          default: rdSel = '0;
        endcase
      end
    end
  end

  assign rdata = DATA_W'(rdSel);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstn)
    $rose(rstn) |-> (pinOut == '0 && pinOe == '0));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctl.wrDataStb == '0) |=> (pinOut == $past(pinOut)));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctl.wrDirStb == '0) |=> (pinOe == $past(pinOe)));

  // R5
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstn)
    (ctl.rdKind == RD_NONE) |-> (rdata == '0));

  logic unusedBits;
  assign unusedBits = ^{BUS_W[0]};
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinOe
);
  bankCtlT ctl;

  gpio_bank_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (pclk),
    .rstn    (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .ctl     (ctl)
  );

  gpio_bank_dpath #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dpath (
    .clk    (pclk),
    .rstn   (presetn),
    .ctl    (ctl),
    .wdata  (pwdata),
    .pinIn  (pinIn),
    .rdata  (prdata),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  // R7: zero wait states
  assign pready = 1'b1;
endmodule

// File: tb/gpio_port_bank_tb.sv
module gpio_port_bank_tb;
  localparam int NP = 3;
  localparam int PW = 24;
  localparam int BW = NP * PW;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready;
  logic [BW-1:0] pinIn = '0;
  logic [BW-1:0] pinOut, pinOe;

  int checks = 0;
  int fails = 0;
  logic [31:0] mData [4];
  logic [31:0] mDir  [4];
  logic [31:0] mPin  [4];

  always #2 pclk = ~pclk;

  gpio_port_bank #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(8)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == 8'(p * 12))       r = mData[p];
      if (a == 8'(p * 12 + 4))   r = mDir[p];
      if (a == 8'('h50 + p * 4)) r = mPin[p];
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] expOut(input bit dir);
    logic [BW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*PW +: PW] = dir ? mDir[p][PW-1:0] : mData[p][PW-1:0];
    return v;
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    for (int p = 0; p < NP; p++) begin
      if (a == 8'(p * 12))     mData[p] = d & MASK;
      if (a == 8'(p * 12 + 4)) mDir[p]  = d & MASK;
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
    modelWrite(a, d);
    // R2 R3 R6 R9: output ports follow the model one edge after the access
    chk("R2 pinOut", 128'(pinOut), 128'(expOut(0)));
    chk("R3 pinOe", 128'(pinOe), 128'(expOut(1)));
  endtask

  task automatic apbRead(input logic [7:0] a, input string tag);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1;
    chk(tag, 128'(prdata), 128'(expRead(a)));
    chk("R7 pready", 128'(pready), 128'(1));
    @(negedge pclk);
    psel = 0; penable = 0;
    #1;
    chk("R10 idle prdata", 128'(prdata), 128'(0));
  endtask

  task automatic setPins(input logic [BW-1:0] v);
    @(negedge pclk);
    pinIn = v;
    for (int p = 0; p < NP; p++) mPin[p] = 32'(v[p*PW +: PW]);
    repeat (2) @(negedge pclk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [BW-1:0] newPins;
    void'($urandom(32'h5EED_2024));
    for (int p = 0; p < 4; p++) begin mData[p] = 0; mDir[p] = 0; mPin[p] = 0; end
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    // R1 reset state
    chk("R1 pinOut", 128'(pinOut), 128'(0));
    chk("R1 pinOe", 128'(pinOe), 128'(0));
    apbRead(8'h00, "R1 data reset");
    apbRead(8'h1C, "R1 dir reset");

    // R2 R3 R9 directed
    apbWrite(8'h00, 32'hFFFF_FFFF);
    apbRead(8'h00, "R9 upper bits zero");
    apbWrite(8'h10, 32'h00A5_5A5A);
    apbRead(8'h10, "R3 dir readback");
    apbWrite(8'h18, 32'h1234_5678);
    apbRead(8'h18, "R2 data readback");

    // R5 R6: absent port D, reserved window, pin regs, misaligned
    apbWrite(8'h24, 32'hDEAD_BEEF);
    apbRead(8'h24, "R5 absent port data");
    apbWrite(8'h28, 32'hDEAD_BEEF);
    apbWrite(8'h30, 32'hFFFF_FFFF);
    apbRead(8'h30, "R5 reserved window");
    apbWrite(8'h4C, 32'hFFFF_FFFF);
    apbWrite(8'h50, 32'hFFFF_FFFF);
    apbRead(8'h50, "R6 pin reg not writable");
    apbWrite(8'h01, 32'hFFFF_FFFF);
    apbRead(8'h01, "R5 misaligned");
    apbRead(8'h00, "R6 data unchanged");
    apbRead(8'h5C, "R5 absent port pins");

    // R8: setup phase alone and penable without psel
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = 8'h0C; pwdata = 32'h0077_7777;
    @(negedge pclk);
    psel = 0; penable = 1;
    @(negedge pclk);
    penable = 0; pwrite = 0;
    apbRead(8'h0C, "R8 no write without access phase");

    // R4 latency: change at setup edge, old value in that access, new next
    setPins({BW{1'b0}});
    @(negedge pclk);
    newPins = BW'({$urandom, $urandom, $urandom});
    pinIn = newPins;
    psel = 1; penable = 0; pwrite = 0; paddr = 8'h54;
    @(negedge pclk);
    penable = 1;
    #1;
    chk("R4 one edge old value", 128'(prdata), 128'(mPin[1]));
    @(negedge pclk);
    psel = 0; penable = 0;
    for (int p = 0; p < NP; p++) mPin[p] = 32'(newPins[p*PW +: PW]);
    apbRead(8'h54, "R4 two edges new value");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int kind = int'($urandom % 4);
      case (kind)
        0: a = 8'(($urandom % 4) * 12 + (($urandom % 2) * 4));
        1: a = 8'('h50 + ($urandom % 4) * 4);
        2: a = 8'('h30 + ($urandom % 8) * 4);
        default: a = 8'($urandom);
      endcase
      case ($urandom % 8)
        0: setPins(BW'({$urandom, $urandom, $urandom}));
        1, 2, 3: apbWrite(a, $urandom);
        default: apbRead(a, "R2 R3 R4 R5 random read");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule